// File: doc/BRIEF.md
# Dual-Lane NOR Flash Block-Erase Sequencer

This block erases a byte range of a parallel NOR flash array whose data bus is made of several 16-bit devices placed side by side. The default is two devices on a 32-bit bus. The host presents a start address, a byte length and a poll timeout, then pulses `start`. The sequencer widens the range outward to whole erase blocks. It clears the device status once, then erases each block in turn by issuing command words and polling status over a simple synchronous memory bus. A write completes in the cycle it is asserted. Read data is returned combinationally in the same cycle as the read strobe.

Every command byte is copied into the low byte of each 16-bit lane, so all devices receive the same command at the same time. A status word counts as ready only when every lane reports ready. It counts as failed when any lane reports an erase fault. When the operation ends, the block pulses `done` and presents `err`, `tmo_err` and `result`. On a clean run `result` is zero. On a fault or timeout it is the failing block's byte offset from the requested start address plus one.

Top module: `nor_erase_seq`

## Requirements
- R1: The erased range runs from the start address rounded down to a 256 KB (2^18 byte) boundary up to start+length rounded up to a 256 KB boundary. Each block in that range is addressed at its first byte, in ascending order. A range of zero blocks issues no erase commands.
- R2: Each command byte appears in bits [7:0] of every 16-bit lane, with bits [15:8] of each lane zero. For example, clear-status is written as 0x00500050.
- R3: The first bus operation after an accepted start is a clear-status write (byte 0x50) to the rounded-down base address.
- R4: For each block, an erase-setup write (0x20) is followed in the next cycle by an erase-confirm write (0xD0) to the same address.
- R5: After confirm, the block reads status at the block address every cycle. It stops polling only when bit 7 of every lane is set (mask 0x00800080 fully set), or on timeout.
- R6: When polling ends, the block writes clear-status (0x50) and then read-array (0xFF) to the block address, in consecutive cycles.
- R7: If bit 5 of any lane (mask 0x00200020) was set in the ready status word, no later block is touched. In that case `err`=1 and `result` = block address − start address + 1, modulo 2^32.
- R8: When every block erases cleanly, `err`=0, `tmo_err`=0 and `result`=0.
- R9: The poll counter allows `tmo_limit` not-ready reads. A further not-ready read (read number `tmo_limit`+1) ends polling. The block then issues the R6 writes, stops with `tmo_err`=1 and `err`=0, and reports `result` as in R7.
- R10: `busy` is low after reset and rises in the cycle after an accepted start. `done` is a one-cycle pulse in the last busy cycle. A `start` seen while `busy` is high is ignored.
- R11: At most one of `bus_rd` and `bus_wr` is high in a cycle, and both are low while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an erase; taken only while idle |
| start_addr | input | ADDR_W | First byte of the requested range |
| length | input | ADDR_W | Byte count of the requested range |
| tmo_limit | input | TMO_W | Number of not-ready status reads allowed per block |
| busy | output | 1 | High while an erase is in progress |
| done | output | 1 | One-cycle pulse at completion |
| err | output | 1 | Erase fault reported by a device |
| tmo_err | output | 1 | Status polling timed out |
| result | output | ADDR_W | Zero on success, else failing block offset plus one |
| bus_addr | output | ADDR_W | Byte address of the current bus operation |
| bus_wr | output | 1 | Write strobe, completes in the same cycle |
| bus_rd | output | 1 | Read strobe, data taken in the same cycle |
| bus_wdata | output | DATA_W | Command word |
| bus_rdata | input | DATA_W | Status word returned by the array |

## Verification
The assertions assume that `bus_rdata` is meaningful only while `bus_rd` is high. They also assume that `tmo_limit`, `start_addr` and `length` hold still from the start pulse until `done`. The poll-counter bound depends on that. The bench changes these inputs only between operations, and the one extra `start` it raises mid-run carries a different range. Its flash model answers reads from a per-block busy count. While busy it returns a word with only one lane ready, so an early exit on partial readiness shows up as a wrong bus sequence.

// File: rtl/nes_pkg.sv
package nes_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_CLR0, ST_SETUP, ST_CONF, ST_POLL, ST_CLRS, ST_ARR, ST_FIN
   } seq_state_e;

   localparam logic [7:0] OP_CLEAR   = 8'h50;
   localparam logic [7:0] OP_ERASE   = 8'h20;
   localparam logic [7:0] OP_CONFIRM = 8'hD0;
   localparam logic [7:0] OP_ARRAY   = 8'hFF;

   localparam int LANE_W   = 16;
   localparam int RDY_BIT  = 7;
   localparam int FAIL_BIT = 5;
endpackage

// File: rtl/nes_lanes.sv
module nes_lanes #(
   parameter int DATA_W = 32
) (
   input  logic [7:0]        op,
   input  logic [DATA_W-1:0] status,
   output logic [DATA_W-1:0] word,
   output logic              rdy_all,
   output logic              fail_any
);
   localparam int LANES = DATA_W / nes_pkg::LANE_W;

   logic [LANES-1:0] rdy_v;
   logic [LANES-1:0] fail_v;
   logic             unused_status;

   if ((DATA_W % nes_pkg::LANE_W) != 0 || LANES < 1) begin : g_bad_width
      $error("nes_lanes: DATA_W must be a nonzero multiple of 16");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign word[g*nes_pkg::LANE_W +: nes_pkg::LANE_W] = {8'h00, op};
      assign rdy_v[g]  = status[g*nes_pkg::LANE_W + nes_pkg::RDY_BIT];
      assign fail_v[g] = status[g*nes_pkg::LANE_W + nes_pkg::FAIL_BIT];
   end

   assign rdy_all       = &rdy_v;
   assign fail_any      = |fail_v;
   assign unused_status = ^status;
endmodule

// File: rtl/nes_span.sv
module nes_span #(
   parameter int ADDR_W    = 32,
   parameter int BLK_SHIFT = 18,
   parameter int NB_W      = ADDR_W + 2 - BLK_SHIFT
) (
   input  logic [ADDR_W-1:0] first,
   input  logic [ADDR_W-1:0] len,
   output logic [ADDR_W-1:0] base,
   output logic [NB_W-1:0]   nblk
);
   localparam int XW = ADDR_W + 2;

   logic [XW-1:0] mask, base_x, last, last_up, span;
   logic          unused_span;

   always_comb begin
      mask    = {{(XW-BLK_SHIFT){1'b0}}, {BLK_SHIFT{1'b1}}};
      base_x  = {2'b00, first} & ~mask;
      last    = {2'b00, first} + {2'b00, len};
      last_up = (last + mask) & ~mask;
      span    = last_up - base_x;
   end

   assign base        = base_x[ADDR_W-1:0];
   assign nblk        = span[XW-1:BLK_SHIFT];
   assign unused_span = ^{span[BLK_SHIFT-1:0], base_x[XW-1:ADDR_W]};
endmodule

// File: rtl/nes_poll_timer.sv
module nes_poll_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             tick,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);
   logic [TMO_W-1:0] cnt;

   assign expired = tick && (cnt == limit);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) cnt <= '0;
      else if (tick && !expired) cnt <= cnt + TMO_W'(1);
   end

   // R9: the count never passes the allowed number of not-ready reads
   p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> cnt <= limit);
endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int BLK_SHIFT = 18,
   parameter int TMO_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [ADDR_W-1:0] length,
   input  logic [TMO_W-1:0]  tmo_limit,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              tmo_err,
   output logic [ADDR_W-1:0] result,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_wr,
   output logic              bus_rd,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata
);
   import nes_pkg::*;

   localparam int          NB_W     = ADDR_W + 2 - BLK_SHIFT;
   localparam [ADDR_W-1:0] BLK_STEP = ADDR_W'(1) << BLK_SHIFT;

   if (BLK_SHIFT < 1 || BLK_SHIFT >= ADDR_W) begin : g_bad_shift
      $error("nor_erase_seq: BLK_SHIFT must lie inside the address width");
   end

   seq_state_e        state;
   logic [ADDR_W-1:0] blk_addr, req_addr, span_base;
   logic [NB_W-1:0]   blk_left, span_nblk;
   logic              fail_q, tmo_q;
   logic [7:0]        op;
   logic              rdy_all, fail_any, tmo_hit;

   nes_span #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .NB_W(NB_W)) u_span (
      .first(start_addr), .len(length), .base(span_base), .nblk(span_nblk));

   nes_lanes #(.DATA_W(DATA_W)) u_lanes (
      .op(op), .status(bus_rdata), .word(bus_wdata),
      .rdy_all(rdy_all), .fail_any(fail_any));

   nes_poll_timer #(.TMO_W(TMO_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .clear(state == ST_CONF),
      .tick(state == ST_POLL && !rdy_all), .limit(tmo_limit),
      .expired(tmo_hit));

   always_comb begin
      bus_wr = 1'b0;
      bus_rd = 1'b0;
      op     = OP_ARRAY;
      unique case (state)
         ST_CLR0, ST_CLRS: begin bus_wr = 1'b1; op = OP_CLEAR;   end
         ST_SETUP:         begin bus_wr = 1'b1; op = OP_ERASE;   end
         ST_CONF:          begin bus_wr = 1'b1; op = OP_CONFIRM; end
         ST_ARR:           begin bus_wr = 1'b1; op = OP_ARRAY;   end
         ST_POLL:          bus_rd = 1'b1;
         default:          ;
      endcase
   end

   assign bus_addr = blk_addr;
   assign busy     = (state != ST_IDLE);
   assign done     = (state == ST_FIN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         blk_addr <= '0;
         req_addr <= '0;
         blk_left <= '0;
         fail_q   <= 1'b0;
         tmo_q    <= 1'b0;
         err      <= 1'b0;
         tmo_err  <= 1'b0;
         result   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               blk_addr <= span_base;
               req_addr <= start_addr;
               blk_left <= span_nblk;
               fail_q   <= 1'b0;
               tmo_q    <= 1'b0;
               err      <= 1'b0;
               tmo_err  <= 1'b0;
               result   <= '0;
               state    <= ST_CLR0;
            end
            ST_CLR0:  state <= (blk_left == '0) ? ST_FIN : ST_SETUP;
            ST_SETUP: state <= ST_CONF;
            ST_CONF:  state <= ST_POLL;
            ST_POLL: begin
               if (rdy_all) begin
                  fail_q <= fail_any;
                  state  <= ST_CLRS;
               end else if (tmo_hit) begin
                  tmo_q <= 1'b1;
                  state <= ST_CLRS;
               end
            end
            ST_CLRS: state <= ST_ARR;
            ST_ARR: begin
               if (tmo_q || fail_q) begin
                  tmo_err <= tmo_q;
                  err     <= fail_q;
                  result  <= blk_addr - req_addr + ADDR_W'(1);
                  state   <= ST_FIN;
               end else if (blk_left == NB_W'(1)) begin
                  state <= ST_FIN;
               end else begin
                  blk_left <= blk_left - NB_W'(1);
                  blk_addr <= blk_addr + BLK_STEP;
                  state    <= ST_SETUP;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_single_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd));
   p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(bus_wr || bus_rd));
   p_done_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
   p_start_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy && bus_wr && bus_wdata[7:0] == OP_CLEAR);
   p_confirm_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_wdata[7:0] == OP_ERASE) |=>
         (bus_wr && bus_wdata[7:0] == OP_CONFIRM && $stable(bus_addr)));
   p_ready_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && rdy_all) |=> (bus_wr && bus_wdata[7:0] == OP_CLEAR));
   p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(err && tmo_err));
endmodule

// File: tb/sim_nor_erase_seq.sv
`timescale 1ns/1ps
module sim_nor_erase_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] start_addr = '0, length = '0;
   logic [15:0] tmo_limit = '0;
   logic        busy, done, err, tmo_err, bus_wr, bus_rd;
   logic [31:0] result, bus_addr, bus_wdata, bus_rdata;

   always #2 clk = ~clk;

   nor_erase_seq u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .length(length), .tmo_limit(tmo_limit), .busy(busy), .done(done),
      .err(err), .tmo_err(tmo_err), .result(result), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata));

   // behavioural flash: per-block busy poll count and fault flag
   int cfg_busy [16];
   bit cfg_fail [16];
   int polls_left = 0;
   bit cur_fail = 1'b0;

   always @(posedge clk) begin
      if (bus_wr && bus_wdata == 32'h00D0_00D0) begin
         polls_left <= cfg_busy[bus_addr[21:18]];
         cur_fail   <= cfg_fail[bus_addr[21:18]];
      end else if (bus_rd && polls_left > 0) begin
         polls_left <= polls_left - 1;
      end
   end
   assign bus_rdata = (polls_left > 0) ? 32'h0000_0080 :
                      (cur_fail ? 32'h00A0_0080 : 32'h0080_0080);

   int          n_chk = 0, n_fail = 0, cycles = 0;
   logic [64:0] expq [$];
   logic [64:0] item;
   logic        exp_err, exp_tmo;
   logic [31:0] exp_res;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference: every bus cycle compared against the predicted stream
   always @(negedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_fail++;
         $display("FAIL R10 watchdog actual=%0d expected<150000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
      if (bus_wr || bus_rd) begin
         if (bus_wr && bus_rd) chk("R11 read and write together", 32'd1, 32'd0);
         else if (expq.size() == 0) chk("R11 unexpected bus operation", bus_addr, 32'hFFFF_FFFF);
         else begin
            item = expq.pop_front();
            chk("R5 operation kind", {31'b0, bus_wr}, {31'b0, item[64]});
            chk("R1 operation address", bus_addr, item[63:32]);
            if (item[64]) chk("R2 command word", bus_wdata, item[31:0]);
         end
      end
   end

   task automatic build(input logic [31:0] s, input logic [31:0] l, input int tmo);
      logic [33:0] b, e;
      logic [31:0] a;
      logic [3:0]  idx;
      int          n;
      b = {2'b00, s} & ~34'h3FFFF;
      e = ({2'b00, s} + {2'b00, l} + 34'h3FFFF) & ~34'h3FFFF;
      n = int'((e - b) >> 18);
      exp_err = 1'b0; exp_tmo = 1'b0; exp_res = 32'h0;
      expq.push_back({1'b1, b[31:0], 32'h0050_0050});            // R3
      for (int i = 0; i < n; i++) begin
         a   = b[31:0] + 32'(i) * 32'h0004_0000;
         idx = a[21:18];
         expq.push_back({1'b1, a, 32'h0020_0020});                // R4
         expq.push_back({1'b1, a, 32'h00D0_00D0});
         if (cfg_busy[idx] > tmo) begin                           // R9
            for (int k = 0; k <= tmo; k++) expq.push_back({1'b0, a, 32'h0});
            expq.push_back({1'b1, a, 32'h0050_0050});
            expq.push_back({1'b1, a, 32'h00FF_00FF});
            exp_tmo = 1'b1; exp_res = a - s + 32'd1;
            break;
         end
         for (int k = 0; k <= cfg_busy[idx]; k++) expq.push_back({1'b0, a, 32'h0});
         expq.push_back({1'b1, a, 32'h0050_0050});                // R6
         expq.push_back({1'b1, a, 32'h00FF_00FF});
         if (cfg_fail[idx]) begin                                 // R7
            exp_err = 1'b1; exp_res = a - s + 32'd1;
            break;
         end
      end
   endtask

   task automatic clear_cfg();
      for (int i = 0; i < 16; i++) begin cfg_busy[i] = 0; cfg_fail[i] = 1'b0; end
   endtask

   task automatic run(input logic [31:0] s, input logic [31:0] l, input int tmo, input bit poke);
      int w;
      build(s, l, tmo);
      start_addr = s; length = l; tmo_limit = 16'(tmo);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R10 busy after start", {31'b0, busy}, 32'd1);
      if (poke) begin
         repeat (3) @(negedge clk);
         start_addr = 32'h0; length = 32'h0020_0000; start = 1'b1;   // R10 ignored
         @(negedge clk);
         start = 1'b0;
      end
      w = 0;
      while (!done && w < 5000) begin @(negedge clk); w++; end
      chk("R10 done pulse seen", {31'b0, done}, 32'd1);
      chk("R7 err flag", {31'b0, err}, {31'b0, exp_err});
      chk("R9 timeout flag", {31'b0, tmo_err}, {31'b0, exp_tmo});
      chk("R8 result value", result, exp_res);
      chk("R1 all bus operations issued", 32'(expq.size()), 32'd0);
      @(negedge clk);
      chk("R10 busy low after done", {31'b0, busy}, 32'd0);
      chk("R10 done single cycle", {31'b0, done}, 32'd0);
      expq.delete();
      repeat (2) @(negedge clk);
   endtask

   initial begin
      clear_cfg();
      repeat (3) @(negedge clk);
      chk("R10 reset busy", {31'b0, busy}, 32'd0);
      chk("R10 reset done", {31'b0, done}, 32'd0);
      chk("R11 reset bus idle", {30'b0, bus_wr, bus_rd}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: one aligned block, some busy polls
      clear_cfg(); cfg_busy[1] = 3;
      run(32'h0004_0000, 32'h0004_0000, 8, 1'b0);
      // R1: unaligned range straddling a boundary, two blocks
      clear_cfg(); cfg_busy[2] = 5;
      run(32'h0007_FFF0, 32'h0000_0020, 8, 1'b0);
      // R7: fault on the middle of three blocks
      clear_cfg(); cfg_busy[0] = 2; cfg_fail[1] = 1'b1; cfg_busy[1] = 1;
      run(32'h0000_0100, 32'h0008_0000, 8, 1'b0);
      // R7: fault on a block below the start address, offset wraps
      clear_cfg(); cfg_fail[0] = 1'b1;
      run(32'h0000_0010, 32'h0000_0004, 8, 1'b0);
      // R9: timeout after tmo_limit+1 not-ready reads
      clear_cfg(); cfg_busy[3] = 10;
      run(32'h000C_0000, 32'h0000_0004, 4, 1'b0);
      // R9: exactly tmo_limit not-ready reads is still a clean erase
      clear_cfg(); cfg_busy[3] = 4;
      run(32'h000C_0000, 32'h0000_0004, 4, 1'b0);
      // R9: zero limit with an immediately ready device
      clear_cfg();
      run(32'h0008_0000, 32'h0004_0000, 0, 1'b0);
      // R1: aligned start with zero length erases nothing
      clear_cfg();
      run(32'h0008_0000, 32'h0000_0000, 4, 1'b0);
      // R10: start raised mid-run is ignored
      clear_cfg(); cfg_busy[0] = 6; cfg_busy[1] = 2;
      run(32'h0000_0000, 32'h0004_0001, 8, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule